// File: doc/BRIEF.md
# Overvoltage Event Filter Counter

This block sits between a per-cycle overvoltage comparator and the latched protection logic of a switching power converter. A single spike (an electrostatic discharge or a surge on the line) must not shut the converter down, while a real, sustained output overvoltage must. Once per switching cycle a strobe marks the moment in the secondary stroke where the comparator result is valid. The block samples the comparator flag at that strobe and keeps an event count.

A cycle that shows overvoltage raises the count by one. A clean cycle lowers it by two, and the count never goes below zero. The trip output latches high when the count reaches the active limit, which is about ten nearly back-to-back events. A two-bit mode selects whether the filter is switched off, uses a fixed internal limit, or uses a programmed limit that cannot be set below the internal one. Once set, the trip stays high until the supervisor asserts the latch-clear (the supply-collapse reset) or the filter is switched off.

Top module: `ovf_event_filter`

## Requirements
- R1: While `rst_n` is low, and at the first clock after it rises, `countOut` is 0 and `tripOut` is 0.
- R2: On a rising clock edge with `cycleStrobe`=1 and `ovFlag`=1 (filter enabled, not tripped, no clear), `countOut` increases by exactly 1.
- R3: On a rising clock edge with `cycleStrobe`=1 and `ovFlag`=0 (filter enabled, not tripped, no clear), `countOut` decreases by 2 and saturates at 0 (1 becomes 0).
- R4: On an edge with `cycleStrobe`=0, `countOut` and `tripOut` keep their values whatever `ovFlag` is.
- R5: On the edge where an increment brings the count to the active limit, `countOut` equals the limit and `tripOut` rises. The count never goes above the limit.
- R6: `modeSel`=2'b00 and 2'b11 select the disabled mode. There, `tripOut` is low at once (combinationally), and the count and the trip latch are cleared at the next edge, so a return to an enabled mode starts from 0 and untripped.
- R7: `modeSel`=2'b01 selects the internal limit, parameter `INT_LIMIT` (default 10). `limitIn` is ignored in this mode.
- R8: `modeSel`=2'b10 selects the external limit `limitIn`. A value below `INT_LIMIT` is raised to `INT_LIMIT`.
- R9: Once `tripOut` is high, further strobes of either polarity leave `countOut` and `tripOut` unchanged.
- R10: An edge with `latchClear`=1 sets `countOut` and `tripOut` to 0. A strobe in the same clock is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycleStrobe | input | 1 | One-clock pulse per switching cycle, marking when the comparator result is valid |
| ovFlag | input | 1 | Comparator result: 1 means the sensed voltage was above the threshold |
| modeSel | input | 2 | 00/11 disabled, 01 internal limit, 10 external limit |
| limitIn | input | CNT_W | Programmed event limit, used in external mode |
| latchClear | input | 1 | Clears the count and the trip latch |
| tripOut | output | 1 | Latched overvoltage trip |
| countOut | output | CNT_W | Current event count |

## Verification
The bench checks the floor of the down-count at counts of 1 and 0. A design that wraps or stops at 1 there would leave a non-zero count and trip too early on later events. It checks that the trip fires on exactly the tenth event and not at a lower programmed value, which catches a limit that is off by one or not clamped. It checks that a tripped latch ignores clean cycles and that the disabled mode masks the trip before the next edge. A design that still counts after tripping, or that lets the trip through while disabled, would fail these. It also checks that a clear coinciding with an overvoltage strobe leaves the count at zero, which catches a clear that loses to the increment.

// File: rtl/ovf_pkg.sv
package ovf_pkg;

  // Mode encoding of modeSel: both 00 and 11 switch the filter off.
  typedef enum logic [1:0] {
    MODE_OFF      = 2'b00,
    MODE_INTERNAL = 2'b01,
    MODE_EXTERNAL = 2'b10,
    MODE_OFF_ALT  = 2'b11
  } ovf_mode_e;

  // Strobes from control to the count datapath; at most one is active.
  typedef struct packed {
    logic clrCount;
    logic incCount;
    logic decCount;
  } ovf_ctrl_t;

  function automatic logic modeEnabled(input logic [1:0] sel);
    return (ovf_mode_e'(sel) == MODE_INTERNAL) || (ovf_mode_e'(sel) == MODE_EXTERNAL);
  endfunction

endpackage

// File: rtl/ovf_count_path.sv
module ovf_count_path
  import ovf_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int INT_LIMIT = 10,
  parameter int INC_STEP  = 1,
  parameter int DEC_STEP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ovf_ctrl_t        ctrl,
  input  logic [1:0]       modeSel,
  input  logic [CNT_W-1:0] limitIn,
  output logic [CNT_W-1:0] countOut,
  output logic             hitLimit
);

  localparam int SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] INT_LIM_V = CNT_W'(INT_LIMIT);
  localparam logic [CNT_W-1:0] DEC_V     = CNT_W'(DEC_STEP);
  localparam logic [SUM_W-1:0] INC_V     = SUM_W'(INC_STEP);

  logic [CNT_W-1:0] countReg;
  logic [CNT_W-1:0] countNext;
  logic [CNT_W-1:0] effLimit;
  logic [SUM_W-1:0] incSum;
  logic [CNT_W-1:0] decValue;

  // Active limit: the internal value, or the programmed one floored at it.
  always_comb begin
    unique case (ovf_mode_e'(modeSel))
      MODE_EXTERNAL: effLimit = (limitIn < INT_LIM_V) ? INT_LIM_V : limitIn;
      default:       effLimit = INT_LIM_V;
    endcase
  end

  // One extra bit so the increment cannot wrap before the comparison.
  assign incSum   = {1'b0, countReg} + INC_V;
  assign hitLimit = (incSum >= {1'b0, effLimit});
  assign decValue = (countReg >= DEC_V) ? (countReg - DEC_V) : '0;

  always_comb begin
    countNext = countReg;
    if (ctrl.clrCount)      countNext = '0;
    else if (ctrl.incCount) countNext = hitLimit ? effLimit : incSum[CNT_W-1:0];
    else if (ctrl.decCount) countNext = decValue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) countReg <= '0;
    else        countReg <= countNext;
  end

  assign countOut = countReg;

  // R2: the count never rises by more than one step per clock.
  assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, countReg} <= ({1'b0, $past(countReg)} + INC_V));

  // R3: a down-count from below the step lands on zero.
  assert_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.decCount && (countReg < DEC_V)) |=> (countReg == '0));

  // R10: a clear strobe leaves a zero count.
  assert_clear_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.clrCount |=> (countReg == '0));

  // R4: with no strobe from control the count holds.
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl.clrCount || ctrl.incCount || ctrl.decCount) |=> $stable(countReg));

endmodule

// File: rtl/ovf_trip_ctrl.sv
module ovf_trip_ctrl
  import ovf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cycleStrobe,
  input  logic       ovFlag,
  input  logic [1:0] modeSel,
  input  logic       latchClear,
  input  logic       hitLimit,
  output ovf_ctrl_t  ctrl,
  output logic       tripOut
);

  logic enabled;
  logic tripReg;
  logic sampleNow;
  logic setTrip;

  assign enabled = modeEnabled(modeSel);

  // A strobe counts only when enabled, untripped and not being cleared.
  assign sampleNow = cycleStrobe && enabled && !latchClear && !tripReg;

  always_comb begin
    ctrl          = '0;
    ctrl.clrCount = latchClear || !enabled;
    ctrl.incCount = sampleNow && ovFlag;
    ctrl.decCount = sampleNow && !ovFlag;
  end

  assign setTrip = ctrl.incCount && hitLimit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     tripReg <= 1'b0;
    else if (latchClear || !enabled) tripReg <= 1'b0;
    else if (setTrip)               tripReg <= 1'b1;
  end

  // The disabled mode masks the trip without waiting for an edge.
  assign tripOut = tripReg && enabled;

  // R9: a trip holds while enabled and not cleared.
  assert_trip_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tripReg && enabled && !latchClear) |=> tripReg);

  // R6: no trip is visible in the disabled mode.
  assert_trip_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> !tripOut);

  // R10: a clear drops the trip latch at the next edge.
  assert_clear_trip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    latchClear |=> !tripReg);

  // R5: the trip can only rise on an overvoltage strobe.
  assert_trip_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tripReg && !(cycleStrobe && ovFlag)) |=> !tripReg);

endmodule

// File: rtl/ovf_event_filter.sv
module ovf_event_filter
  import ovf_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int INT_LIMIT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cycleStrobe,
  input  logic             ovFlag,
  input  logic [1:0]       modeSel,
  input  logic [CNT_W-1:0] limitIn,
  input  logic             latchClear,
  output logic             tripOut,
  output logic [CNT_W-1:0] countOut
);

  ovf_ctrl_t ctrlBus;
  logic      hitLimit;

  ovf_trip_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cycleStrobe(cycleStrobe),
    .ovFlag     (ovFlag),
    .modeSel    (modeSel),
    .latchClear (latchClear),
    .hitLimit   (hitLimit),
    .ctrl       (ctrlBus),
    .tripOut    (tripOut)
  );

  ovf_count_path #(
    .CNT_W    (CNT_W),
    .INT_LIMIT(INT_LIMIT),
    .INC_STEP (1),
    .DEC_STEP (2)
  ) u_path (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrlBus),
    .modeSel (modeSel),
    .limitIn (limitIn),
    .countOut(countOut),
    .hitLimit(hitLimit)
  );

endmodule

// File: tb/sim_ovf_event_filter.sv
`timescale 1ns/1ps
module sim_ovf_event_filter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cycleStrobe = 1'b0;
  logic       ovFlag = 1'b0;
  logic [1:0] modeSel = 2'b01;
  logic [7:0] limitIn = 8'd0;
  logic       latchClear = 1'b0;
  logic       tripOut;
  logic [7:0] countOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ovf_event_filter u0 (
    .clk(clk), .rst_n(rst_n), .cycleStrobe(cycleStrobe), .ovFlag(ovFlag),
    .modeSel(modeSel), .limitIn(limitIn), .latchClear(latchClear),
    .tripOut(tripOut), .countOut(countOut)
  );

  // Row: strobe, ov, mode[1:0], limit[7:0], clear, expCount[7:0], expTrip, req[3:0]
  localparam int NVEC = 16;
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b1,1'b1,2'b01,8'd0 ,1'b0,8'd1,1'b0,4'd2 },  // R2
    {1'b1,1'b1,2'b01,8'd0 ,1'b0,8'd2,1'b0,4'd2 },  // R2
    {1'b0,1'b1,2'b01,8'd0 ,1'b0,8'd2,1'b0,4'd4 },  // R4 flag without strobe
    {1'b1,1'b0,2'b01,8'd0 ,1'b0,8'd0,1'b0,4'd3 },  // R3 2 -> 0
    {1'b1,1'b0,2'b01,8'd0 ,1'b0,8'd0,1'b0,4'd3 },  // R3 floor at 0
    {1'b1,1'b1,2'b01,8'd0 ,1'b0,8'd1,1'b0,4'd2 },  // R2
    {1'b1,1'b0,2'b01,8'd0 ,1'b0,8'd0,1'b0,4'd3 },  // R3 1 -> 0
    {1'b1,1'b1,2'b01,8'd0 ,1'b0,8'd1,1'b0,4'd2 },  // R2
    {1'b1,1'b1,2'b01,8'd0 ,1'b0,8'd2,1'b0,4'd2 },  // R2
    {1'b1,1'b1,2'b01,8'd0 ,1'b0,8'd3,1'b0,4'd2 },  // R2
    {1'b1,1'b1,2'b01,8'd0 ,1'b1,8'd0,1'b0,4'd10},  // R10 clear beats strobe
    {1'b1,1'b1,2'b10,8'd12,1'b0,8'd1,1'b0,4'd8 },  // R8
    {1'b1,1'b1,2'b10,8'd12,1'b0,8'd2,1'b0,4'd8 },  // R8
    {1'b1,1'b1,2'b00,8'd12,1'b0,8'd0,1'b0,4'd6 },  // R6 mode 00
    {1'b1,1'b1,2'b11,8'd12,1'b0,8'd0,1'b0,4'd6 },  // R6 mode 11
    {1'b1,1'b1,2'b01,8'd3 ,1'b0,8'd1,1'b0,4'd7 }   // R7
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkState(input string tag, input int expCnt, input bit expTrip);
    check(countOut == 8'(expCnt), {tag, " count"}, countOut, expCnt);
    check(tripOut == expTrip, {tag, " trip"}, tripOut, expTrip);
  endtask

  // Drive at the falling edge, sample 1 ns after the next rising edge.
  task automatic step(input bit s, input bit ov, input bit clr);
    @(negedge clk);
    cycleStrobe = s; ovFlag = ov; latchClear = clr;
    @(posedge clk);
    #1;
    cycleStrobe = 1'b0; latchClear = 1'b0;
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual hung expected done");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkState("R1 in reset", 0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    checkState("R1 after reset", 0, 1'b0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      modeSel = VEC[i][23:22];
      limitIn = VEC[i][21:14];
      cycleStrobe = VEC[i][25]; ovFlag = VEC[i][24]; latchClear = VEC[i][13];
      @(posedge clk);
      #1;
      cycleStrobe = 1'b0; latchClear = 1'b0;
      check(countOut == VEC[i][12:5], $sformatf("R%0d vector %0d count", VEC[i][3:0], i),
            countOut, VEC[i][12:5]);
      check(tripOut == VEC[i][4], $sformatf("R%0d vector %0d trip", VEC[i][3:0], i),
            tripOut, VEC[i][4]);
    end

    // R7/R5: internal limit 10, limitIn=3 ignored
    modeSel = 2'b01; limitIn = 8'd3;
    step(0, 0, 1);
    for (int k = 0; k < 9; k++) step(1, 1, 0);
    checkState("R7 nine events", 9, 1'b0);
    step(1, 1, 0);
    checkState("R5 tenth event trips", 10, 1'b1);

    // R9: tripped state frozen
    step(1, 1, 0);
    checkState("R9 ov after trip", 10, 1'b1);
    step(1, 0, 0);
    checkState("R9 clean after trip", 10, 1'b1);

    // R6: disabled masks immediately, clears at edge
    @(negedge clk);
    modeSel = 2'b00;
    #1;
    check(tripOut == 1'b0, "R6 immediate mask trip", tripOut, 0);
    @(posedge clk);
    #1;
    checkState("R6 cleared in disabled", 0, 1'b0);
    modeSel = 2'b01;
    step(0, 0, 0);
    checkState("R6 re-enabled untripped", 0, 1'b0);

    // R10: clear with overvoltage strobe while tripped
    for (int k = 0; k < 10; k++) step(1, 1, 0);
    checkState("R5 trip again", 10, 1'b1);
    step(1, 1, 1);
    checkState("R10 clear when tripped", 0, 1'b0);

    // R3: down-count from 5
    for (int k = 0; k < 5; k++) step(1, 1, 0);
    step(1, 0, 0);
    checkState("R3 5 to 3", 3, 1'b0);
    step(1, 0, 0);
    checkState("R3 3 to 1", 1, 1'b0);
    step(1, 0, 0);
    checkState("R3 1 to 0", 0, 1'b0);

    // R8: external limit 12
    modeSel = 2'b10; limitIn = 8'd12;
    for (int k = 0; k < 11; k++) step(1, 1, 0);
    checkState("R8 eleven of twelve", 11, 1'b0);
    step(1, 1, 0);
    checkState("R8 twelfth trips", 12, 1'b1);
    step(0, 0, 1);

    // R8: external limit below internal is raised to 10
    limitIn = 8'd4;
    for (int k = 0; k < 4; k++) step(1, 1, 0);
    checkState("R8 clamp no trip at 4", 4, 1'b0);
    for (int k = 0; k < 6; k++) step(1, 1, 0);
    checkState("R8 clamp trips at 10", 10, 1'b1);

    done = 1'b1;
    finishRun();
  end

endmodule